// File: doc/BRIEF.md
# Configurable Interrupt Router Crossbar

This block steers a set of interrupt request lines onto a smaller or equal set of output lines. Every output owns one control word that names which input drives it and whether the output is live at all. A disabled output stays low, and any input may be chosen by any output. One trusted agent, identified by an agent number on a simple write-only register bus, programs these words. A write from any other agent changes nothing and is answered with a one-cycle error pulse.

Whether the router handles edge or level interrupts is set at build time through a trigger-kind parameter: value 1 selects edge handling and value 4 selects level handling. In edge mode a rising edge on the chosen input becomes a one-cycle pulse. In level mode the output copies the chosen input through one register stage.

A separate lookup port converts an output index into the number the parent interrupt controller uses. It searches a small build-time table of ranges, each given as an output base, a parent base and a count. The answer is registered, and it carries a valid flag that stays low when the index falls in no range.

Top module: `irq_route_xbar`

## Requirements
- R1: While `rst` is high at a clock edge, and after that edge, `irq_out` is all zero, `wr_err` is 0, `lk_valid` is 0 and `lk_parent` is 0. Every control word is cleared to input 0, disabled.
- R2: A trusted write sets the control word of output `wr_addr`. `wr_data[SEL_W-1:0]` is the input number and `wr_data[SEL_W]` is the enable bit. The new word steers the output from the next clock edge, and any input can be routed to any output.
- R3: An output whose enable bit is 0 is driven low whatever its selected input does.
- R4: With TRIG_KIND = 1 (edge), an output goes high for exactly one cycle, one edge after its selected input is first seen high having been low at the previous edge. It is never high on two consecutive cycles.
- R5: With TRIG_KIND = 4 (level), an enabled output equals its selected input as sampled at the previous clock edge, so it rises and falls with one cycle of latency.
- R6: Inputs other than the selected one have no effect on an output.
- R7: A write whose `wr_agent` differs from SYSCTL_ID (default 3) leaves every control word unchanged. It raises `wr_err` for the one cycle after the write edge. A trusted write leaves `wr_err` at 0.
- R8: One edge after `lk_idx` is applied, `lk_valid` is 1 and `lk_parent` = parent base + (`lk_idx` − output base) for the first table range, in table order, with output base ≤ `lk_idx` < output base + count. The default table is {0,360,4}, {4,100,2}, {5,500,3}.
- R9: When `lk_idx` falls in no range, `lk_valid` is 0 and `lk_parent` is 0 one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_IN | Interrupt request inputs, bit i is input number i |
| wr_en | input | 1 | Register write strobe |
| wr_agent | input | AGENT_W | Number of the agent issuing the write |
| wr_addr | input | ADDR_W | Output index whose control word is written |
| wr_data | input | SEL_W+1 | Enable bit on top, input number below |
| wr_err | output | 1 | Error response for a write from an untrusted agent |
| irq_out | output | NUM_OUT | Routed interrupt outputs |
| lk_idx | input | IDX_W | Output index to translate |
| lk_valid | output | 1 | Translation hit |
| lk_parent | output | PAR_W | Parent interrupt number, zero on a miss |

## Verification
Some properties are checked on every cycle. No disabled output is high. In edge builds, no output is high two cycles in a row. An error response only follows an untrusted write, and such a write never alters the stored control words. A miss on the lookup always yields parent number zero. Other behaviour can only be shown by the bench scenarios. These cover routing of every input to every output in both trigger builds, rejection of stray inputs, the exact cycle of each pulse and level change, and the translated numbers across every index, including the overlap where the first range in table order must win.

// File: rtl/irx_pkg.sv
package irx_pkg;
  localparam int unsigned IRX_TRIG_EDGE  = 1;
  localparam int unsigned IRX_TRIG_LEVEL = 4;
endpackage

// File: rtl/irx_cfg_regs.sv
module irx_cfg_regs #(
  parameter int unsigned NUM_OUT   = 8,
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned AGENT_W   = 4,
  parameter int unsigned SYSCTL_ID = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [AGENT_W-1:0]       wr_agent,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [SEL_W:0]           wr_data,
  output logic                     wr_err,
  output logic [NUM_OUT*SEL_W-1:0] sel_flat,
  output logic [NUM_OUT-1:0]       en_vec
);
  logic trusted;
  assign trusted = (wr_agent == AGENT_W'(SYSCTL_ID));

  always_ff @(posedge clk) begin
    if (rst) wr_err <= 1'b0;
    else     wr_err <= wr_en && !trusted;
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        sel_flat[o*SEL_W +: SEL_W] <= '0;
        en_vec[o]                  <= 1'b0;
      end else if (wr_en && trusted && (wr_addr == ADDR_W'(o))) begin
        sel_flat[o*SEL_W +: SEL_W] <= wr_data[SEL_W-1:0];
        en_vec[o]                  <= wr_data[SEL_W];
      end
    end
  end
endmodule

// File: rtl/irx_out_lane.sv
module irx_out_lane
  import irx_pkg::*;
#(
  parameter int unsigned NUM_IN    = 16,
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned TRIG_KIND = IRX_TRIG_EDGE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] irq_in,
  input  logic [SEL_W-1:0]  sel,
  input  logic              en,
  output logic              out
);
  logic picked;
  assign picked = irq_in[sel];

  if (TRIG_KIND == IRX_TRIG_LEVEL) begin : g_level
    always_ff @(posedge clk) begin
      if (rst) out <= 1'b0;
      else     out <= en & picked;
    end
  end else begin : g_edge
    logic hist;
    always_ff @(posedge clk) begin
      if (rst) begin
        hist <= 1'b0;
        out  <= 1'b0;
      end else begin
        hist <= picked;
        out  <= en & picked & ~hist;
      end
    end
  end
endmodule

// File: rtl/irx_range_xlate.sv
module irx_range_xlate #(
  parameter int unsigned IDX_W      = 8,
  parameter int unsigned PAR_W      = 10,
  parameter int unsigned NUM_RANGES = 3,
  parameter logic [NUM_RANGES*IDX_W-1:0] RANGE_OBASE = '0,
  parameter logic [NUM_RANGES*PAR_W-1:0] RANGE_PBASE = '0,
  parameter logic [NUM_RANGES*IDX_W-1:0] RANGE_LIMIT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_valid,
  output logic [PAR_W-1:0] lk_parent
);
  logic             hit;
  logic [PAR_W-1:0] par;

  always_comb begin
    logic [IDX_W:0]   lo;
    logic [IDX_W:0]   hi;
    logic [IDX_W-1:0] off;
    hit = 1'b0;
    par = '0;
    for (int r = NUM_RANGES - 1; r >= 0; r--) begin
      lo  = {1'b0, RANGE_OBASE[r*IDX_W +: IDX_W]};
      hi  = lo + {1'b0, RANGE_LIMIT[r*IDX_W +: IDX_W]};
      off = lk_idx - RANGE_OBASE[r*IDX_W +: IDX_W];
      if (({1'b0, lk_idx} >= lo) && ({1'b0, lk_idx} < hi)) begin
        hit = 1'b1;
        par = RANGE_PBASE[r*PAR_W +: PAR_W] + PAR_W'(off);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_valid  <= 1'b0;
      lk_parent <= '0;
    end else begin
      lk_valid  <= hit;
      lk_parent <= par;
    end
  end
endmodule

// File: rtl/irq_route_xbar.sv
module irq_route_xbar
  import irx_pkg::*;
#(
  parameter int unsigned NUM_IN     = 16,
  parameter int unsigned NUM_OUT    = 8,
  parameter int unsigned TRIG_KIND  = IRX_TRIG_EDGE,
  parameter int unsigned AGENT_W    = 4,
  parameter int unsigned SYSCTL_ID  = 3,
  parameter int unsigned IDX_W      = 8,
  parameter int unsigned PAR_W      = 10,
  parameter int unsigned NUM_RANGES = 3,
  parameter logic [NUM_RANGES*IDX_W-1:0] RANGE_OBASE = {8'd5, 8'd4, 8'd0},
  parameter logic [NUM_RANGES*PAR_W-1:0] RANGE_PBASE = {10'd500, 10'd100, 10'd360},
  parameter logic [NUM_RANGES*IDX_W-1:0] RANGE_LIMIT = {8'd3, 8'd2, 8'd4},
  localparam int unsigned SEL_W  = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
  localparam int unsigned ADDR_W = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IN-1:0]  irq_in,
  input  logic               wr_en,
  input  logic [AGENT_W-1:0] wr_agent,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [SEL_W:0]     wr_data,
  output logic               wr_err,
  output logic [NUM_OUT-1:0] irq_out,
  input  logic [IDX_W-1:0]   lk_idx,
  output logic               lk_valid,
  output logic [PAR_W-1:0]   lk_parent
);
  logic [NUM_OUT*SEL_W-1:0]         sel_flat;
  logic [NUM_OUT-1:0]               en_vec;
  logic [NUM_OUT*(SEL_W+1)-1:0]     cfg_state;

  assign cfg_state = {en_vec, sel_flat};

  irx_cfg_regs #(
    .NUM_OUT(NUM_OUT), .SEL_W(SEL_W), .ADDR_W(ADDR_W),
    .AGENT_W(AGENT_W), .SYSCTL_ID(SYSCTL_ID)
  ) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_agent(wr_agent),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_err(wr_err),
    .sel_flat(sel_flat), .en_vec(en_vec)
  );

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_lane
    irx_out_lane #(
      .NUM_IN(NUM_IN), .SEL_W(SEL_W), .TRIG_KIND(TRIG_KIND)
    ) lane_i (
      .clk(clk), .rst(rst), .irq_in(irq_in),
      .sel(sel_flat[o*SEL_W +: SEL_W]), .en(en_vec[o]), .out(irq_out[o])
    );
  end

  irx_range_xlate #(
    .IDX_W(IDX_W), .PAR_W(PAR_W), .NUM_RANGES(NUM_RANGES),
    .RANGE_OBASE(RANGE_OBASE), .RANGE_PBASE(RANGE_PBASE), .RANGE_LIMIT(RANGE_LIMIT)
  ) xlate_i (
    .clk(clk), .rst(rst), .lk_idx(lk_idx),
    .lk_valid(lk_valid), .lk_parent(lk_parent)
  );
endmodule

// File: rtl/irx_chk.sv
module irx_chk
  import irx_pkg::*;
#(
  parameter int unsigned NUM_OUT   = 8,
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned TRIG_KIND = IRX_TRIG_EDGE,
  parameter int unsigned AGENT_W   = 4,
  parameter int unsigned SYSCTL_ID = 3,
  parameter int unsigned PAR_W     = 10
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         wr_en,
  input logic [AGENT_W-1:0]           wr_agent,
  input logic                         wr_err,
  input logic [NUM_OUT-1:0]           irq_out,
  input logic [NUM_OUT-1:0]           en_vec,
  input logic [NUM_OUT*(SEL_W+1)-1:0] cfg_state,
  input logic                         lk_valid,
  input logic [PAR_W-1:0]             lk_parent
);
  logic rogue;
  assign rogue = wr_en && (wr_agent != AGENT_W'(SYSCTL_ID));

  AST_ERR_AFTER_ROGUE: assert property (@(posedge clk) disable iff (rst)
    wr_err |-> $past(rogue)); // R7

  AST_ROGUE_KEEPS_CFG: assert property (@(posedge clk) disable iff (rst)
    rogue |=> $stable(cfg_state)); // R7

  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (rst)
    (irq_out & ~$past(en_vec)) == '0); // R3

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |-> (lk_parent == '0)); // R9

  if (TRIG_KIND != IRX_TRIG_LEVEL) begin : g_edge_chk
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      (irq_out & $past(irq_out)) == '0); // R4
  end
endmodule

bind irq_route_xbar irx_chk #(
  .NUM_OUT(NUM_OUT), .SEL_W(SEL_W), .TRIG_KIND(TRIG_KIND),
  .AGENT_W(AGENT_W), .SYSCTL_ID(SYSCTL_ID), .PAR_W(PAR_W)
) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_agent(wr_agent), .wr_err(wr_err),
  .irq_out(irq_out), .en_vec(en_vec), .cfg_state(cfg_state),
  .lk_valid(lk_valid), .lk_parent(lk_parent)
);

// File: tb/irq_route_xbar_tb_top.sv
`timescale 1ns/1ps
module irq_route_xbar_tb_top;
  localparam int NI = 16;
  localparam int NO = 8;
  localparam int SW = 4;
  localparam int AW = 3;
  localparam int ID = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NI-1:0] irq_in = '0;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_agent = '0;
  logic [AW-1:0] wr_addr = '0;
  logic [SW:0]   wr_data = '0;
  logic [7:0]    lk_idx = '0;

  logic          err_e, err_l, val_e, val_l;
  logic [NO-1:0] out_e, out_l;
  logic [9:0]    par_e, par_l;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_route_xbar #(.TRIG_KIND(1)) dut_i (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .wr_agent(wr_agent),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_err(err_e), .irq_out(out_e),
    .lk_idx(lk_idx), .lk_valid(val_e), .lk_parent(par_e)
  );

  irq_route_xbar #(.TRIG_KIND(4)) dut_lvl_i (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .wr_agent(wr_agent),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_err(err_l), .irq_out(out_l),
    .lk_idx(lk_idx), .lk_valid(val_l), .lk_parent(par_l)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input int agent, input int addr, input int sel, input bit en);
    @(negedge clk);
    wr_en    = 1'b1;
    wr_agent = 4'(agent);
    wr_addr  = AW'(addr);
    wr_data  = {en, SW'(sel)};
    @(negedge clk);
    wr_en    = 1'b0;
  endtask

  function automatic int exp_parent(input int idx, output bit hit);
    hit = 1'b1;
    if (idx < 4)      return 360 + idx;
    if (idx < 6)      return 100 + idx - 4;
    if (idx < 8)      return 500 + idx - 5;
    hit = 1'b0;
    return 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 out_e", int'(out_e), 0);
    chk("R1 out_l", int'(out_l), 0);
    chk("R1 err", int'(err_e), 0);
    chk("R1 valid", int'(val_e), 0);
    chk("R1 parent", int'(par_e), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 out after release", int'(out_e | out_l), 0);

    // R2 R4 R5 R6 sweep of every input onto every output
    for (int o = 0; o < NO; o++) begin
      for (int s = 0; s < NI; s++) begin
        cfg_write(ID, o, s, 1'b1);
        irq_in = '0;
        @(negedge clk);
        irq_in = ~(NI'(1) << s);
        @(negedge clk);
        chk("R6 edge stray", int'(out_e[o]), 0);
        chk("R6 level stray", int'(out_l[o]), 0);
        irq_in = '1;
        @(negedge clk);
        chk("R2 R4 edge pulse", int'(out_e[o]), 1);
        chk("R2 R5 level rise", int'(out_l[o]), 1);
        @(negedge clk);
        chk("R4 pulse one cycle", int'(out_e[o]), 0);
        chk("R5 level held", int'(out_l[o]), 1);
        irq_in = ~(NI'(1) << s);
        @(negedge clk);
        chk("R5 level fall", int'(out_l[o]), 0);
        irq_in = '0;
      end
    end

    // R3 disabled output stays low
    cfg_write(ID, 0, 3, 1'b0);
    irq_in = '0;
    @(negedge clk);
    irq_in = NI'(1) << 3;
    @(negedge clk);
    chk("R3 edge disabled", int'(out_e[0]), 0);
    chk("R3 level disabled", int'(out_l[0]), 0);
    @(negedge clk);
    chk("R3 level disabled later", int'(out_l[0]), 0);
    irq_in = '0;

    // R7 untrusted writes
    cfg_write(ID, 1, 5, 1'b1);
    chk("R7 trusted no err", int'(err_e), 0);
    cfg_write(9, 1, 6, 1'b1);
    chk("R7 rogue err", int'(err_e), 1);
    chk("R7 rogue err lvl", int'(err_l), 1);
    @(negedge clk);
    chk("R7 err one cycle", int'(err_e), 0);
    irq_in = NI'(1) << 6;
    @(negedge clk);
    chk("R7 rogue sel ignored edge", int'(out_e[1]), 0);
    chk("R7 rogue sel ignored lvl", int'(out_l[1]), 0);
    irq_in = (NI'(1) << 6) | (NI'(1) << 5);
    @(negedge clk);
    chk("R7 old sel kept edge", int'(out_e[1]), 1);
    chk("R7 old sel kept lvl", int'(out_l[1]), 1);
    irq_in = '0;
    cfg_write(0, 2, 0, 1'b0);
    chk("R7 rogue err agent0", int'(err_e), 1);

    // R8 R9 translation sweep
    for (int i = 0; i < 20; i++) begin
      bit hit;
      int ep;
      ep = exp_parent(i, hit);
      lk_idx = 8'(i);
      @(negedge clk);
      if (hit) begin
        chk("R8 valid", int'(val_e), 1);
        chk("R8 parent", int'(par_e), ep);
      end else begin
        chk("R9 invalid", int'(val_e), 0);
        chk("R9 parent zero", int'(par_e), 0);
      end
    end
    lk_idx = 8'd255;
    @(negedge clk);
    chk("R9 top index", int'(val_l), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule